// File: doc/BRIEF.md
# Branch resolve and squash controller

This controller handles control hazards for a five-stage in-order pipeline with one conditional branch, a compare-equal branch. In its default speculating mode it lets fetch carry on down the sequential path. When the branch reaches the memory stage, the controller reads the equality result and the target address that were computed in execute. If the branch is taken, it selects the target for the program counter. In that same cycle it turns the three younger instructions into noops: the one being fetched, the one in decode and the one in execute.

A second, selectable mode does not speculate. When decode holds a branch, the controller freezes the program counter and feeds noops into decode until the branch has resolved. The instruction after the branch therefore waits in fetch for three extra cycles. A request from the data-hazard logic to stall is honoured unless a taken branch redirects in that cycle, because the redirect always wins.

The controller also keeps two saturating counters. One counts squashed instructions and the other counts branch stall cycles, so that the exact penalty can be measured.

The stall-mode tracking is a three-state machine:
- `ST_FREE`: no branch is pending.
- `ST_FREE` to `ST_WAIT_EXE`: taken when stall mode is on, decode holds the branch, and there is no data-hazard stall.
- `ST_WAIT_EXE` to `ST_WAIT_MEM`: taken unconditionally.
- `ST_WAIT_MEM` to `ST_FREE`: taken unconditionally, in the cycle the branch resolves.

Top module: `brsq_ctrl`

## Requirements
- R1: After reset both counters read 0, and with noop opcodes everywhere all control outputs are 0.
- R2: When the memory-stage opcode is the branch code 3'b100 and the equality flag is 1, the following all hold in that same cycle: `pc_sel_o`=1, `pc_tgt_o` equals `mem_tgt_i`, and all three flush outputs are 1.
- R3: A memory-stage branch with equality flag 0, or any other memory-stage opcode, gives `pc_sel_o`=0 and `flush_em_o`=0.
- R4: In speculate mode (`stall_mode_i`=0), a branch in decode or execute raises no hold and no flush.
- R5: In stall mode, a branch in decode with no data-hazard stall raises `hold_pc_o` and `flush_fd_o` in that cycle and in the next two cycles. The exception is the third cycle when the branch is taken there: in that case `pc_sel_o` is raised instead and `hold_pc_o` is 0.
- R6: Without a taken branch, `dh_stall_i`=1 raises `hold_pc_o`, `hold_fd_o` and `bubble_de_o`.
- R7: A taken branch releases `hold_pc_o`, `hold_fd_o` and `bubble_de_o`, even when `dh_stall_i`=1.
- R8: On every taken branch the squash counter grows, one clock edge later, by 1 plus one for each of the decode and execute opcodes that is not the noop code 3'b111. It saturates at 65535.
- R9: The stall counter grows by 1 in every cycle a stall-mode branch is pending (three cycles per branch). It saturates at 65535.
- R10: In stall mode, a branch in decode together with `dh_stall_i`=1 does not start the branch wait: `flush_fd_o`=0, `hold_fd_o`=1, and the stall counter does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_mode_i | input | 1 | 1 selects stall-at-decode, 0 selects speculate-not-taken |
| dh_stall_i | input | 1 | Stall request from the data-hazard logic |
| dec_op_i | input | 3 | Opcode held in the fetch/decode register |
| exe_op_i | input | 3 | Opcode held in the decode/execute register |
| mem_op_i | input | 3 | Opcode held in the execute/memory register |
| mem_eq_i | input | 1 | Equality result latched in execute |
| mem_tgt_i | input | 16 | Branch target latched in execute |
| pc_sel_o | output | 1 | 1 loads the program counter with the target |
| pc_tgt_o | output | 16 | Target address for the program counter |
| hold_pc_o | output | 1 | Freeze the program counter |
| hold_fd_o | output | 1 | Freeze the fetch/decode register |
| bubble_de_o | output | 1 | Load a noop into the decode/execute register |
| flush_fd_o | output | 1 | Load a noop into the fetch/decode register |
| flush_de_o | output | 1 | Load a noop into the decode/execute register (squash) |
| flush_em_o | output | 1 | Load a noop into the execute/memory register (squash) |
| sq_cnt_o | output | 16 | Saturating count of squashed instructions |
| stl_cnt_o | output | 16 | Saturating count of branch stall cycles |

## Verification
The redirect of a taken branch and the data-hazard stall can fall in the same cycle. So can the redirect and the final cycle of a stall-mode branch wait. The first collision is provoked by an exhaustive sweep over the stage opcodes, the equality flag and the stall request. The second is provoked by running a stall-mode branch to resolution with the flag both set and clear. In each collision the control outputs must show the redirect alone, with every hold released. The squash counter must grow by the number of real instructions thrown away, and the stall counter by exactly three per branch.

// File: rtl/brsq_pkg.sv
package brsq_pkg;

    // Stall-mode branch tracking states
    typedef enum logic [1:0] {
        ST_FREE     = 2'd0,
        ST_WAIT_EXE = 2'd1,
        ST_WAIT_MEM = 2'd2
    } brwait_t;

    // Per-cycle pipeline control bundle
    typedef struct packed {
        logic pc_sel;
        logic hold_pc;
        logic hold_fd;
        logic bubble_de;
        logic flush_fd;
        logic flush_de;
        logic flush_em;
    } pipe_ctl_t;

endpackage

// File: rtl/brsq_resolve.sv
module brsq_resolve #(
    parameter int              OP_W      = 3,
    parameter logic [OP_W-1:0] BEQ_CODE  = 3'b100,
    parameter logic [OP_W-1:0] NOOP_CODE = 3'b111
) (
    input  logic [OP_W-1:0] dec_op_i,
    input  logic [OP_W-1:0] exe_op_i,
    input  logic [OP_W-1:0] mem_op_i,
    input  logic            mem_eq_i,
    output logic            taken_o,
    output logic [1:0]      sq_inc_o
);

    logic dec_real;
    logic exe_real;

    always_comb begin
        taken_o  = (mem_op_i == BEQ_CODE) && mem_eq_i;
        dec_real = (dec_op_i != NOOP_CODE);
        exe_real = (exe_op_i != NOOP_CODE);
        if (taken_o) begin
            // the fetch slot always counts as one discarded instruction
            sq_inc_o = 2'd1 + {1'b0, dec_real} + {1'b0, exe_real};
        end else begin
            sq_inc_o = 2'd0;
        end
    end

endmodule

// File: rtl/brsq_stall_fsm.sv
module brsq_stall_fsm
    import brsq_pkg::*;
#(
    parameter int              OP_W     = 3,
    parameter logic [OP_W-1:0] BEQ_CODE = 3'b100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_mode_i,
    input  logic            dh_stall_i,
    input  logic [OP_W-1:0] dec_op_i,
    output logic            pending_o
);

    brwait_t state_q;
    brwait_t state_d;
    logic    start;

    assign start = stall_mode_i && (dec_op_i == BEQ_CODE) && !dh_stall_i;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        pending_o = 1'b0;
        unique case (state_q)
            ST_FREE: begin
                pending_o = start;
                if (start) state_d = ST_WAIT_EXE;
            end
            ST_WAIT_EXE: begin
                pending_o = 1'b1;
                state_d   = ST_WAIT_MEM;
            end
            ST_WAIT_MEM: begin
                pending_o = 1'b1;
                state_d   = ST_FREE;
            end
            default: begin
                pending_o = 1'b0;
                state_d   = ST_FREE;
            end
        endcase
    end

    // R5: a branch wait always runs to the memory stage before freeing
    p_wait_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_EXE) |=> (state_q == ST_WAIT_MEM));

endmodule

// File: rtl/brsq_sat_ctr.sv
module brsq_sat_ctr #(
    parameter int W     = 16,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc_i,
    output logic [W-1:0]     cnt_o
);

    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W:0]   sum;

    assign sum   = {1'b0, cnt_q} + (W+1)'(inc_i);
    assign cnt_o = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (sum[W]) cnt_q <= MAX;
        else             cnt_q <= sum[W-1:0];
    end

    // R8 and R9: a full counter stays full
    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAX) |=> (cnt_q == MAX));

    // R9: the count never goes down
    p_no_decrease_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/brsq_ctrl.sv
module brsq_ctrl
    import brsq_pkg::*;
#(
    parameter int              OP_W      = 3,
    parameter int              ADDR_W    = 16,
    parameter int              CNT_W     = 16,
    parameter logic [OP_W-1:0] BEQ_CODE  = 3'b100,
    parameter logic [OP_W-1:0] NOOP_CODE = 3'b111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_mode_i,
    input  logic              dh_stall_i,
    input  logic [OP_W-1:0]   dec_op_i,
    input  logic [OP_W-1:0]   exe_op_i,
    input  logic [OP_W-1:0]   mem_op_i,
    input  logic              mem_eq_i,
    input  logic [ADDR_W-1:0] mem_tgt_i,
    output logic              pc_sel_o,
    output logic [ADDR_W-1:0] pc_tgt_o,
    output logic              hold_pc_o,
    output logic              hold_fd_o,
    output logic              bubble_de_o,
    output logic              flush_fd_o,
    output logic              flush_de_o,
    output logic              flush_em_o,
    output logic [CNT_W-1:0]  sq_cnt_o,
    output logic [CNT_W-1:0]  stl_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic       taken;
    logic [1:0] sq_inc;
    logic       pend;
    pipe_ctl_t  ctl;

    brsq_resolve #(
        .OP_W     (OP_W),
        .BEQ_CODE (BEQ_CODE),
        .NOOP_CODE(NOOP_CODE)
    ) u_resolve (
        .dec_op_i(dec_op_i),
        .exe_op_i(exe_op_i),
        .mem_op_i(mem_op_i),
        .mem_eq_i(mem_eq_i),
        .taken_o (taken),
        .sq_inc_o(sq_inc)
    );

    brsq_stall_fsm #(
        .OP_W    (OP_W),
        .BEQ_CODE(BEQ_CODE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_mode_i(stall_mode_i),
        .dh_stall_i  (dh_stall_i),
        .dec_op_i    (dec_op_i),
        .pending_o   (pend)
    );

    brsq_sat_ctr #(.W(CNT_W), .INC_W(2)) u_sq_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .inc_i(sq_inc),
        .cnt_o(sq_cnt_o)
    );

    brsq_sat_ctr #(.W(CNT_W), .INC_W(2)) u_stl_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .inc_i({1'b0, pend}),
        .cnt_o(stl_cnt_o)
    );

    // Priority: redirect, then data-hazard stall, then branch wait
    always_comb begin
        ctl = '0;
        if (taken) begin
            ctl.pc_sel   = 1'b1;
            ctl.flush_fd = 1'b1;
            ctl.flush_de = 1'b1;
            ctl.flush_em = 1'b1;
        end else if (dh_stall_i) begin
            ctl.hold_pc   = 1'b1;
            ctl.hold_fd   = 1'b1;
            ctl.bubble_de = 1'b1;
        end else if (pend) begin
            ctl.hold_pc  = 1'b1;
            ctl.flush_fd = 1'b1;
        end
    end

    assign pc_sel_o    = ctl.pc_sel;
    assign pc_tgt_o    = mem_tgt_i;
    assign hold_pc_o   = ctl.hold_pc;
    assign hold_fd_o   = ctl.hold_fd;
    assign bubble_de_o = ctl.bubble_de;
    assign flush_fd_o  = ctl.flush_fd;
    assign flush_de_o  = ctl.flush_de;
    assign flush_em_o  = ctl.flush_em;

    // R7: a redirect never coexists with a freeze
    p_redirect_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_o |-> (!hold_pc_o && !hold_fd_o && !bubble_de_o));

    // R2: the redirect always comes with the full three-stage squash
    p_flush_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_o |-> (flush_fd_o && flush_de_o && flush_em_o));

    // R3: the deepest flush only happens on a redirect
    p_deep_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_em_o |-> pc_sel_o);

    // R5: a pending branch wait freezes fetch unless it redirects
    p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !pc_sel_o) |-> hold_pc_o);

    // R9: each pending cycle adds one stall count
    p_stall_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && stl_cnt_o != CNT_MAX) |=> (stl_cnt_o == $past(stl_cnt_o) + 1'b1));

endmodule

// File: tb/brsq_ctrl_tb.sv
module brsq_ctrl_tb_top;

    localparam time        CYC  = 20ns;
    localparam logic [2:0] BEQ  = 3'b100;
    localparam logic [2:0] ADD  = 3'b000;
    localparam logic [2:0] NOOP = 3'b111;
    localparam int         MAXC = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_mode, dh_stall, mem_eq;
    logic [2:0]  dec_op, exe_op, mem_op;
    logic [15:0] mem_tgt;
    logic        pc_sel, hold_pc, hold_fd, bubble_de, flush_fd, flush_de, flush_em;
    logic [15:0] pc_tgt, sq_cnt, stl_cnt;

    int checks = 0;
    int errors = 0;
    int exp_sq = 0;
    int exp_st = 0;
    bit done   = 1'b0;

    always #(CYC/2) clk = ~clk;

    brsq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .stall_mode_i(stall_mode), .dh_stall_i(dh_stall),
        .dec_op_i(dec_op), .exe_op_i(exe_op), .mem_op_i(mem_op), .mem_eq_i(mem_eq),
        .mem_tgt_i(mem_tgt), .pc_sel_o(pc_sel), .pc_tgt_o(pc_tgt), .hold_pc_o(hold_pc),
        .hold_fd_o(hold_fd), .bubble_de_o(bubble_de), .flush_fd_o(flush_fd),
        .flush_de_o(flush_de), .flush_em_o(flush_em), .sq_cnt_o(sq_cnt), .stl_cnt_o(stl_cnt)
    );

    function automatic logic [2:0] op_of(int k);
        return (k == 0) ? BEQ : ((k == 1) ? ADD : NOOP);
    endfunction

    function automatic int sat(int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ctl order: {pc_sel, hold_pc, hold_fd, bubble_de, flush_fd, flush_de, flush_em}
    task automatic cyc(input logic m, input logic dh, input logic [2:0] d, input logic [2:0] e,
                       input logic [2:0] mo, input logic eq, input logic [6:0] exp_ctl,
                       input int dsq, input int dst, input string req);
        stall_mode = m; dh_stall = dh; dec_op = d; exe_op = e; mem_op = mo; mem_eq = eq;
        mem_tgt = mem_tgt + 16'h0111;
        #5;
        chk(req, {pc_sel, hold_pc, hold_fd, bubble_de, flush_fd, flush_de, flush_em}, exp_ctl);
        if (exp_ctl[6]) chk({req, " target R2"}, pc_tgt, mem_tgt);
        chk("R8 squash count", sq_cnt, exp_sq);
        chk("R9 stall count", stl_cnt, exp_st);
        @(posedge clk);
        exp_sq = sat(exp_sq + dsq);
        exp_st = sat(exp_st + dst);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CYC * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        stall_mode = 0; dh_stall = 0; dec_op = NOOP; exe_op = NOOP; mem_op = NOOP;
        mem_eq = 0; mem_tgt = 16'h1000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, quiet pipeline
        cyc(0, 0, NOOP, NOOP, NOOP, 0, 7'b0000000, 0, 0, "R1 idle");

        // R2 R3 R4 R6 R7 R8: exhaustive sweep in speculate mode
        for (int dh = 0; dh < 2; dh++)
          for (int mk = 0; mk < 3; mk++)
            for (int eq = 0; eq < 2; eq++)
              for (int dk = 0; dk < 3; dk++)
                for (int ek = 0; ek < 3; ek++) begin
                    logic tk;
                    logic fz;
                    int   inc;
                    tk  = (op_of(mk) == BEQ) && (eq == 1);
                    fz  = (dh == 1) && !tk;
                    inc = tk ? 1 + int'(op_of(dk) != NOOP) + int'(op_of(ek) != NOOP) : 0;
                    cyc(0, logic'(dh), op_of(dk), op_of(ek), op_of(mk), logic'(eq),
                        {tk, fz, fz, fz, tk, tk, tk}, inc, 0,
                        tk ? (dh == 1 ? "R7 redirect over stall" : "R2 taken squash")
                           : (dh == 1 ? "R6 data stall" : "R3 R4 no redirect"));
                end

        // R5 R9: stall-mode branch, not taken then taken
        for (int t = 0; t < 2; t++) begin
            cyc(1, 0, BEQ,  ADD,  ADD, 0, 7'b0100100, 0, 1, "R5 wait in decode");
            cyc(1, 0, NOOP, BEQ,  ADD, 0, 7'b0100100, 0, 1, "R5 wait in execute");
            if (t == 0)
                cyc(1, 0, NOOP, NOOP, BEQ, 0, 7'b0100100, 0, 1, "R5 resolve not taken");
            else
                cyc(1, 0, NOOP, NOOP, BEQ, 1, 7'b1000111, 1, 1, "R5 resolve taken");
            cyc(1, 0, ADD,  NOOP, NOOP, 0, 7'b0000000, 0, 0, "R5 released");
        end

        // R10: a branch in decode under a data stall does not start the wait
        cyc(1, 1, BEQ,  ADD,  ADD, 0, 7'b0111000, 0, 0, "R10 dh holds branch");
        cyc(1, 0, BEQ,  ADD,  ADD, 0, 7'b0100100, 0, 1, "R10 wait begins");
        cyc(1, 1, NOOP, BEQ,  ADD, 0, 7'b0111000, 0, 1, "R10 wait with dh");
        cyc(1, 0, NOOP, NOOP, BEQ, 1, 7'b1000111, 1, 1, "R7 stall-mode redirect");
        // R4: speculate mode with branches upstream
        cyc(0, 0, BEQ,  BEQ,  ADD, 1, 7'b0000000, 0, 0, "R4 speculate no hold");

        // R8: saturation of the squash counter (3 per cycle)
        stall_mode = 0; dh_stall = 0; dec_op = ADD; exe_op = ADD; mem_op = BEQ; mem_eq = 1;
        for (int i = 0; i < 21900; i++) begin
            @(posedge clk);
            exp_sq = sat(exp_sq + 3);
        end
        @(negedge clk);
        mem_op = ADD;
        #5;
        chk("R8 squash saturates", sq_cnt, MAXC);
        chk("R8 saturated expected", exp_sq, MAXC);

        // R9: saturation of the stall counter (branch in decode every cycle)
        stall_mode = 1; dec_op = BEQ; exe_op = NOOP; mem_op = ADD; mem_eq = 0;
        for (int i = 0; i < 65600; i++) @(posedge clk);
        @(negedge clk);
        stall_mode = 0; dec_op = NOOP;
        #5;
        chk("R9 stall saturates", stl_cnt, MAXC);
        chk("R8 squash still full", sq_cnt, MAXC);

        // R1: reset clears both counters
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk("R1 squash reset", sq_cnt, 0);
        chk("R1 stall reset", stl_cnt, 0);

        done = 1'b1;
        finish_run();
    end

endmodule